// File: doc/BRIEF.md
# Four-bit LFSR step counter with binary readout

This block is a 4-bit linear-feedback shift-register counter. On every enabled clock it moves to the next state of a fixed 15-state sequence that starts at the seed value 4'b1111. Beside the raw register it gives the ordinary binary count, which is the number of steps that lead from the seed to the current state. That count comes from a fixed, fully unrolled match against the 15 sequence states, so synthesis sees plain comparators and an encoder. It never sees a search loop whose length depends on data.

A load port can write any 4-bit value into the register. One of those values is the all-zero state, which stepping can never reach. Once the register holds all zeros it stays there until a reset or a new load. The decoder reports that state with an invalid flag and the reserved count 15, so the value 15 is never taken for a real count.

The register picks its next value through four named modes, checked in this priority order: MODE_RESET (synchronous reset writes the seed), MODE_LOAD (writes the load value), MODE_STEP (applies the feedback rule) and MODE_HOLD (keeps the value). The only transitions are the steps between sequence states, from state k to state k+1 modulo 15, and the self-loop of the all-zero state.

Top module: `lfsr4_step_counter`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `state` is 4'b1111, `count` is 0 and `invalid` is 0.
- R2: On a clock edge with `rst` and `load` low and `en` high, `state` becomes {state[1]^state[0], state[3:1]}. Bit 3 takes the XOR of the old bits 1 and 0, and the old bits 3..1 move down to bits 2..0.
- R3: For a nonzero `state`, `count` equals the number of R2 steps from 4'b1111 to that state. It runs from 0 to 14 and returns to 0 after exactly 15 steps.
- R4: `invalid` is 1 exactly when `state` is 4'b0000, and `count` is then 15 (4'hF). For every other state `invalid` is 0.
- R5: On a clock edge with `rst` low and `load` high, `state` takes `load_value`, whatever the value of `en`. Any of the 16 values is accepted, 4'b0000 included.
- R6: On a clock edge with `rst`, `load` and `en` all low, `state` and `count` keep their values.
- R7: Once `state` is 4'b0000, enabled steps leave it at 4'b0000 until a reset or a load.
- R8: `rst` has priority over `load` and `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to the seed, active high |
| en | input | 1 | Step enable |
| load | input | 1 | Load strobe, takes priority over `en` |
| load_value | input | 4 | State written when `load` is high |
| state | output | 4 | Raw shift-register contents |
| count | output | 4 | Steps since the seed, or 15 when invalid |
| invalid | output | 1 | High when `state` is all zeros |

## Verification
Each control input (`rst`, `load`, `en`) acts at the next rising edge, so `state` is due one cycle after the stimulus. `count` and `invalid` decode `state` combinationally and are therefore due in the same cycle as the new `state`. The bench changes inputs and reads outputs one nanosecond after each rising edge. A result is thus read exactly one edge after its stimulus, and no read falls on an edge. The expected values come from a step counter and a feedback model kept in the bench, and these are compared over more than two full periods and all 16 loadable values.

// File: rtl/lfsr4_pkg.sv
`timescale 1ns/1ps
package lfsr4_pkg;

    localparam int STATE_W = 4;
    localparam int COUNT_W = 4;
    localparam int PERIOD  = (1 << STATE_W) - 1;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [COUNT_W-1:0] count_t;

    localparam state_t SEED     = '1;
    localparam count_t SENTINEL = count_t'(PERIOD);

    typedef enum logic [1:0] {
        MODE_RESET,
        MODE_LOAD,
        MODE_STEP,
        MODE_HOLD
    } mode_e;

    // One feedback step: new top bit from the two lowest bits.
    function automatic state_t lfsr_step(input state_t s);
        return {s[1] ^ s[0], s[STATE_W-1:1]};
    endfunction

    // State reached after n steps from the seed (used at elaboration only).
    function automatic state_t state_at(input int n);
        state_t s;
        s = SEED;
        for (int k = 0; k < n; k++) begin
            s = lfsr_step(s);
        end
        return s;
    endfunction

endpackage

// File: rtl/lfsr4_mode_sel.sv
`timescale 1ns/1ps
module lfsr4_mode_sel
    import lfsr4_pkg::*;
(
    input  logic  rst_i,
    input  logic  load_i,
    input  logic  en_i,
    output mode_e mode_o
);

    always_comb begin
        if (rst_i) begin
            mode_o = MODE_RESET;
        end else if (load_i) begin
            mode_o = MODE_LOAD;
        end else if (en_i) begin
            mode_o = MODE_STEP;
        end else begin
            mode_o = MODE_HOLD;
        end
    end

endmodule

// File: rtl/lfsr4_core.sv
`timescale 1ns/1ps
module lfsr4_core
    import lfsr4_pkg::*;
(
    input  logic   clk,
    input  mode_e  mode_i,
    input  state_t load_value_i,
    output state_t state_o
);

    state_t q;
    state_t q_next;

    // Next-value selection by mode.
    always_comb begin
        unique case (mode_i)
            MODE_RESET: q_next = SEED;
            MODE_LOAD:  q_next = load_value_i;
            MODE_STEP:  q_next = lfsr_step(q);
            MODE_HOLD:  q_next = q;
            default:    q_next = q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

    assign state_o = q;

endmodule

// File: rtl/lfsr4_decoder.sv
`timescale 1ns/1ps
module lfsr4_decoder
    import lfsr4_pkg::*;
(
    input  state_t state_i,
    output count_t count_o,
    output logic   invalid_o
);

    logic [PERIOD-1:0] hit;

    // One comparator per sequence position; reference states fixed at elaboration.
    generate
        for (genvar i = 0; i < PERIOD; i++) begin : g_match
            localparam state_t REF_STATE = state_at(i);
            assign hit[i] = (state_i == REF_STATE);
        end
    endgenerate

    // Encode the matching position; no match means the all-zero lockup state.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < PERIOD; i++) begin
            if (hit[i]) begin
                count_o = count_o | count_t'(i);
            end
        end
        invalid_o = ~|hit;
        if (invalid_o) begin
            count_o = SENTINEL;
        end
    end

endmodule

// File: rtl/lfsr4_step_counter.sv
`timescale 1ns/1ps
module lfsr4_step_counter
    import lfsr4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       load,
    input  logic [3:0] load_value,
    output logic [3:0] state,
    output logic [3:0] count,
    output logic       invalid
);

    mode_e mode;

    lfsr4_mode_sel i_mode_sel (
        .rst_i  (rst),
        .load_i (load),
        .en_i   (en),
        .mode_o (mode)
    );

    lfsr4_core i_core (
        .clk          (clk),
        .mode_i       (mode),
        .load_value_i (load_value),
        .state_o      (state)
    );

    lfsr4_decoder i_decoder (
        .state_i   (state),
        .count_o   (count),
        .invalid_o (invalid)
    );

    // R1: reset yields the seed.
    a_r1_reset_seed: assert property (@(posedge clk)
        rst |=> (state == 4'b1111));

    // R8: reset overrides load and enable.
    a_r8_reset_priority: assert property (@(posedge clk)
        (rst && load) |=> (state == 4'b1111));

    // R2: feedback step rule.
    a_r2_step_rule: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (state == {$past(state[1]) ^ $past(state[0]), $past(state[3:1])}));

    // R3: enabled step advances the count modulo 15.
    a_r3_count_advance: assert property (@(posedge clk) disable iff (rst)
        (en && !load && !invalid) |=>
            (count == (($past(count) == 4'd14) ? 4'd0 : $past(count) + 4'd1)));

    // R4: invalid flag tracks the all-zero state and forces the sentinel.
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (state == 4'b0000 && count == 4'hF));
    a_r4_valid_range: assert property (@(posedge clk) disable iff (rst)
        !invalid |-> (state != 4'b0000 && count != 4'hF));

    // R5: load writes the given value.
    a_r5_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == $past(load_value)));

    // R6: no enable, no load: hold.
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(state));

    // R7: lockup persists without load.
    a_r7_stuck: assert property (@(posedge clk) disable iff (rst)
        (invalid && !load) |=> invalid);

endmodule

// File: tb/test_lfsr4_step_counter.sv
`timescale 1ns/1ps
module test_lfsr4_step_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [3:0] load_value = 4'b0000;
    logic [3:0] state;
    logic [3:0] count;
    logic       invalid;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    lfsr4_step_counter i_lfsr4_step_counter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .load       (load),
        .load_value (load_value),
        .state      (state),
        .count      (count),
        .invalid    (invalid)
    );

    function automatic logic [3:0] ref_step(input logic [3:0] s);
        return {s[1] ^ s[0], s[3:1]};
    endfunction

    function automatic logic [3:0] ref_count(input logic [3:0] v);
        logic [3:0] s;
        if (v == 4'b0000) return 4'hF;
        s = 4'b1111;
        for (int k = 0; k < 15; k++) begin
            if (s == v) return 4'(k);
            s = ref_step(s);
        end
        return 4'hF;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; load = 1'b0;
        tick();
        rst = 1'b0;
        chk("R1 state", state, 4'b1111);
        chk("R1 count", count, 4'd0);
        chk("R1 invalid", {3'b0, invalid}, 4'd0);
    endtask

    task automatic t_two_periods();
        logic [3:0] rs;
        logic [3:0] rc;
        rs = 4'b1111; rc = 4'd0;
        en = 1'b1;
        for (int n = 0; n < 33; n++) begin
            tick();
            rs = ref_step(rs);
            rc = (rc == 4'd14) ? 4'd0 : rc + 4'd1;
            chk("R2 state", state, rs);
            chk("R3 count", count, rc);
            chk("R4 invalid", {3'b0, invalid}, 4'd0);
        end
        en = 1'b0;
    endtask

    task automatic t_hold();
        logic [3:0] s0;
        logic [3:0] c0;
        s0 = state; c0 = count;
        en = 1'b0; load = 1'b0;
        for (int n = 0; n < 5; n++) begin
            tick();
            chk("R6 state", state, s0);
            chk("R6 count", count, c0);
        end
    endtask

    task automatic t_load_each();
        for (int v = 0; v < 16; v++) begin
            load = 1'b1; en = 1'b1; load_value = 4'(v);
            tick();
            load = 1'b0; en = 1'b0;
            chk("R5 state", state, 4'(v));
            chk("R3 count", count, ref_count(4'(v)));
            chk("R4 invalid", {3'b0, invalid}, (v == 0) ? 4'd1 : 4'd0);
        end
    endtask

    task automatic t_zero_stuck();
        load = 1'b1; load_value = 4'b0000;
        tick();
        load = 1'b0; en = 1'b1;
        for (int n = 0; n < 6; n++) begin
            tick();
            chk("R7 state", state, 4'b0000);
            chk("R4 count", count, 4'hF);
            chk("R7 invalid", {3'b0, invalid}, 4'd1);
        end
        load = 1'b1; load_value = 4'b0110;
        tick();
        load = 1'b0; en = 1'b0;
        chk("R5 recover", state, 4'b0110);
        chk("R3 count", count, 4'd9);
    endtask

    task automatic t_reset_priority();
        rst = 1'b1; load = 1'b1; en = 1'b1; load_value = 4'b0101;
        tick();
        rst = 1'b0; load = 1'b0; en = 1'b0;
        chk("R8 state", state, 4'b1111);
        chk("R8 count", count, 4'd0);
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_two_periods();
        t_hold();
        t_load_each();
        t_zero_stuck();
        t_reset_priority();
        t_two_periods();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule